// File: doc/BRIEF.md
# Dual-Lane to Single-Lane Byte Serializer

This block sits on the transmit side of a physical coding sublayer. It takes a 16-bit word that carries two bytes per word-clock period, each byte with its own enable and error qualifier, and turns it into a single-byte stream that runs at twice the word rate. Every byte slot leaves with one enable and one error flag.

The whole block runs on the byte clock. The word clock is the byte clock divided by two, with rising edges aligned. A word-phase input marks the byte-clock edge on which the word inputs are sampled. The word inputs stay stable for the two byte cycles of each word. A frame may open or close on either byte lane. Only the lanes that are qualified appear with enable high. The stream comes out without gaps, and every byte reaches the output after the same fixed number of cycles.

Top module: `dual_lane_serializer`

## Requirements
- R1: Bit 1 of `in_en` and `in_er` qualifies `in_data[15:8]`. Bit 0 qualifies `in_data[7:0]`. Each error bit travels with its own byte onto `out_er`.
- R2: The upper byte of a word (bits 15:8) is emitted first. The lower byte (bits 7:0) follows in the next byte cycle.
- R3: A word is sampled only on a byte-clock edge where `word_phase` is high. One word is consumed every two byte cycles.
- R4: If a word is sampled on edge n, its upper slot is on the outputs from edge n+3 and its lower slot from edge n+4.
- R5: A frame may start or end on either lane. A word with `in_en` = 2'b01 or 2'b10 yields enable low in the unqualified slot and enable high in the other slot.
- R6: A slot whose enable and error are both low is output with `out_en` = 0, `out_er` = 0 and `out_data` = 8'h00, whatever the input byte holds.
- R7: A slot with enable low and error high is forwarded as carrier extension. The output has `out_en` = 0, `out_er` = 1, and the byte is passed through.
- R8: Consecutive words with both enables high produce `out_en` high in every byte cycle, with no idle slot between them.
- R9: While `rst_n` is low, `out_en`, `out_er` and `out_data` are zero. After release they stay zero until the first sampled word reaches the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low reset |
| word_phase | input | 1 | High on the byte edge where the word is sampled |
| in_data | input | 16 | Two-byte input word; upper byte goes out first |
| in_en | input | 2 | Per-lane enable; bit 1 belongs to the upper byte |
| in_er | input | 2 | Per-lane error; bit 1 belongs to the upper byte |
| out_data | output | 8 | Serialized byte |
| out_en | output | 1 | Byte enable |
| out_er | output | 1 | Byte error or carrier extension |

## Verification
The assertions assume that `word_phase` toggles on every byte cycle once reset is released, and that the word inputs do not change during the low half of the phase. Under those conditions, the slot seen at the outputs can be traced back to a fixed past edge. The latency checks also assume the default latency. The stimulus meets these assumptions by driving every word, including idle words, through one task. That task raises the phase and applies the word on one falling edge, and lowers the phase on the next falling edge without touching the data.

// File: rtl/dls_pkg.sv
`timescale 1ns/1ps
package dls_pkg;
    parameter int BYTE_W = 8;
    parameter int LANES  = 2;
    localparam int WORD_W = BYTE_W * LANES;

    typedef struct packed {
        logic              en;
        logic              er;
        logic [BYTE_W-1:0] data;
    } byte_slot_t;

    typedef byte_slot_t [LANES-1:0] word_slots_t;
endpackage

// File: rtl/dls_word_capture.sv
`timescale 1ns/1ps
module dls_word_capture
    import dls_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_phase,
    input  logic [WORD_W-1:0] in_data,
    input  logic [LANES-1:0]  in_en,
    input  logic [LANES-1:0]  in_er,
    output word_slots_t       word_o,
    output logic              fresh_o
);
    typedef struct packed {
        word_slots_t word;
        logic        fresh;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.fresh = 1'b0;
        if (word_phase) begin
            st_d.fresh = 1'b1;
            for (int i = 0; i < LANES; i++) begin
                st_d.word[i].en   = in_en[i];
                st_d.word[i].er   = in_er[i];
                st_d.word[i].data = in_data[i*BYTE_W +: BYTE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o  = st_q.word;
    assign fresh_o = st_q.fresh;
endmodule

// File: rtl/dls_lane_pick.sv
`timescale 1ns/1ps
module dls_lane_pick
    import dls_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  word_slots_t word_i,
    input  logic        fresh_i,
    output byte_slot_t  slot_o
);
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [IDX_W-1:0] TOP_LANE = IDX_W'(LANES - 1);

    typedef struct packed {
        byte_slot_t       slot;
        logic [IDX_W-1:0] idx;
    } pick_state_t;

    pick_state_t      st_d, st_q;
    logic [IDX_W-1:0] sel;
    byte_slot_t       src;

    always_comb begin
        st_d = st_q;
        sel  = fresh_i ? TOP_LANE : st_q.idx;
        src  = word_i[sel];
        st_d.slot.en   = src.en;
        st_d.slot.er   = src.er;
        st_d.slot.data = (src.en || src.er) ? src.data : '0;
        st_d.idx       = (sel == '0) ? '0 : sel - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot_o = st_q.slot;
endmodule

// File: rtl/dls_slot_pipe.sv
`timescale 1ns/1ps
module dls_slot_pipe
    import dls_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  byte_slot_t slot_i,
    output byte_slot_t slot_o
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign slot_o = slot_i;
        end else begin : g_regs
            byte_slot_t stage_d [STAGES];
            byte_slot_t stage_q [STAGES];

            always_comb begin
                stage_d[0] = slot_i;
                for (int k = 1; k < STAGES; k++) begin
                    stage_d[k] = stage_q[k-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
                end else begin
                    for (int k = 0; k < STAGES; k++) stage_q[k] <= stage_d[k];
                end
            end

            assign slot_o = stage_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/dual_lane_serializer.sv
`timescale 1ns/1ps
module dual_lane_serializer
    import dls_pkg::*;
#(
    parameter int LATENCY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_phase,
    input  logic [WORD_W-1:0] in_data,
    input  logic [LANES-1:0]  in_en,
    input  logic [LANES-1:0]  in_er,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_en,
    output logic              out_er
);
    localparam int PIPE_STAGES = (LATENCY > 1) ? LATENCY - 1 : 0;

    word_slots_t cap_word;
    logic        cap_fresh;
    byte_slot_t  picked;
    byte_slot_t  final_slot;

    dls_word_capture u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_phase (word_phase),
        .in_data    (in_data),
        .in_en      (in_en),
        .in_er      (in_er),
        .word_o     (cap_word),
        .fresh_o    (cap_fresh)
    );

    dls_lane_pick u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_i  (cap_word),
        .fresh_i (cap_fresh),
        .slot_o  (picked)
    );

    dls_slot_pipe #(.STAGES(PIPE_STAGES)) u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .slot_i (picked),
        .slot_o (final_slot)
    );

    assign out_data = final_slot.data;
    assign out_en   = final_slot.en;
    assign out_er   = final_slot.er;
endmodule

// File: rtl/dual_lane_serializer_chk.sv
`timescale 1ns/1ps
// Timing windows below assume the default latency of three edges.
module dual_lane_serializer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        word_phase,
    input logic [15:0] in_data,
    input logic [1:0]  in_en,
    input logic [1:0]  in_er,
    input logic [7:0]  out_data,
    input logic        out_en,
    input logic        out_er
);
    logic [2:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    // R9: nothing reaches the outputs before the first word can
    a_r9_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst <= 3'd3) |-> (!out_en && !out_er && out_data == 8'h00));

    // R6: an unqualified slot carries no byte
    a_r6_idle_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_en && !out_er) |-> (out_data == 8'h00));

    // R1 R2 R4: upper lane appears first, at the fixed latency
    a_r2_upper_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd6 && $past(word_phase, 4)) |->
        (out_en == $past(in_en[1], 4) && out_er == $past(in_er[1], 4) &&
         out_data == (($past(in_en[1], 4) || $past(in_er[1], 4)) ? $past(in_data[15:8], 4) : 8'h00)));

    // R1 R2 R4: lower lane follows one cycle later
    a_r2_lower_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd6 && $past(word_phase, 5)) |->
        (out_en == $past(in_en[0], 5) && out_er == $past(in_er[0], 5) &&
         out_data == (($past(in_en[0], 5) || $past(in_er[0], 5)) ? $past(in_data[7:0], 5) : 8'h00)));
endmodule

bind dual_lane_serializer dual_lane_serializer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_phase (word_phase),
    .in_data    (in_data),
    .in_en      (in_en),
    .in_er      (in_er),
    .out_data   (out_data),
    .out_en     (out_en),
    .out_er     (out_er)
);

// File: tb/dual_lane_serializer_tb.sv
`timescale 1ns/1ps
module dual_lane_serializer_tb;
    typedef struct {
        logic       en;
        logic       er;
        logic [7:0] data;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_phase = 1'b0;
    logic [15:0] in_data = '0;
    logic [1:0]  in_en = '0;
    logic [1:0]  in_er = '0;
    logic [7:0]  out_data;
    logic        out_en;
    logic        out_er;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   drv_started = 1'b0;
    bit   mon_done = 1'b0;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    dual_lane_serializer u_dut (
        .clk (clk), .rst_n (rst_n), .word_phase (word_phase),
        .in_data (in_data), .in_en (in_en), .in_er (in_er),
        .out_data (out_data), .out_en (out_en), .out_er (out_er)
    );

    task automatic check_slot(input string tag, input logic en, input logic er, input logic [7:0] d);
        n_checks++;
        if (out_en !== en || out_er !== er || out_data !== d) begin
            n_fail++;
            $display("FAIL %s: got en=%0b er=%0b data=%02h, expected en=%0b er=%0b data=%02h",
                     tag, out_en, out_er, out_data, en, er, d);
        end
    endtask

    function automatic exp_t make_exp(input logic en, input logic er, input logic [7:0] d, input string tag);
        exp_t e;
        e.en = en;
        e.er = er;
        e.data = (en || er) ? d : 8'h00;
        e.tag = tag;
        return e;
    endfunction

    task automatic send_word(input logic [15:0] d, input logic [1:0] en, input logic [1:0] er, input string tag);
        @(negedge clk);
        word_phase = 1'b1;
        in_data = d;
        in_en = en;
        in_er = er;
        exp_q.push_back(make_exp(en[1], er[1], d[15:8], tag));
        exp_q.push_back(make_exp(en[0], er[0], d[7:0], tag));
        drv_started = 1'b1;
        @(negedge clk);
        word_phase = 1'b0;
    endtask

    // monitor: first three samples must be quiet, then one slot per cycle
    initial begin
        exp_t e;
        wait (drv_started);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_slot("R9 quiet after release", 1'b0, 1'b0, 8'h00);
        end
        @(negedge clk);
        while (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            check_slot(e.tag, e.en, e.er, e.data);
            @(negedge clk);
        end
        mon_done = 1'b1;
    end

    initial begin
        repeat (4) @(negedge clk);
        check_slot("R9 held in reset", 1'b0, 1'b0, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        send_word(16'hA5C3, 2'b00, 2'b00, "R6 R4 idle data dropped");
        send_word(16'h1234, 2'b00, 2'b00, "R6 idle");
        send_word(16'h9955, 2'b01, 2'b00, "R5 start on lower lane");
        send_word(16'h5555, 2'b11, 2'b00, "R8 R2 R3 full word");
        send_word(16'h55D5, 2'b11, 2'b00, "R8 R2 full word");
        send_word(16'h0102, 2'b11, 2'b00, "R8 R2 R3 full word");
        send_word(16'h3344, 2'b11, 2'b10, "R1 error on upper lane");
        send_word(16'h6677, 2'b11, 2'b01, "R1 error on lower lane");
        send_word(16'hABCD, 2'b10, 2'b00, "R5 end on upper lane");
        send_word(16'h0F0F, 2'b00, 2'b11, "R7 carrier extension");
        send_word(16'hFFFF, 2'b00, 2'b00, "R6 idle data dropped");
        send_word(16'hC0DE, 2'b00, 2'b10, "R7 extension upper only");
        send_word(16'hD500, 2'b10, 2'b00, "R5 start on upper lane");
        send_word(16'hBEEF, 2'b11, 2'b00, "R8 R2 full word");
        send_word(16'h42FF, 2'b01, 2'b01, "R5 R1 end on lower lane with error");
        for (int i = 0; i < 3; i++) send_word(16'h0000, 2'b00, 2'b00, "R6 trailing idle");
        for (int i = 0; i < 4; i++) send_word(16'h7E7E, 2'b00, 2'b00, "R6 drain");
        wait (mon_done);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got no completion, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule